// File: doc/BRIEF.md
# Multi-Mode Quadrature Position Counter

This block keeps a position count driven by two external inputs, A and B. It runs in one of four counting modes, chosen at run time: full 4x quadrature, pulse with direction, count up, and count down. Both inputs pass through a two-flop synchronizer. The synchronized levels can be inverted and swapped, and an edge detector then turns them into up and down count strokes. The count wraps around a programmable maximum position.

Software uses a simple register port. A write strobe with an address writes a register, and read data follows the address combinationally. Four registers are visible: the position count, the maximum position, a 16-bit decoder control word and a 16-bit run control word. The run control word holds the count-enable bit. The design has two parts under a thin top. A control part handles synchronization and edge decoding, and sends a small struct of count strobes to a datapath that owns the registers.

Top module: `quad_pos_counter`

## Requirements
- R1: After reset, the position count is 0, the phase-error flag is 0, the maximum position reads 0xFFFFFFFF, and both control words read 0. Counting is therefore disabled after reset.
- R2: Decoder control bits 15:14 select the mode: 0 quadrature, 1 pulse/direction, 2 up, 3 down. In quadrature mode, every edge of A or B gives one count. The (A,B) walk 00→01→11→10→00 counts up and the reverse walk counts down.
- R3: In quadrature mode, a change of both A and B in one sample gives no count and sets a sticky phase-error flag. Only reset clears this flag.
- R4: In pulse/direction mode, only a rising edge of A counts. B high counts up and B low counts down. Edges on B alone give no count.
- R5: In up and down modes, B is ignored. Decoder bit 11 set to 0 counts only rising edges of A, and set to 1 counts both edges of A.
- R6: Bit 3 of the run control word enables counting. While it is 0, input edges leave the count unchanged.
- R7: A write to the position count takes effect only when the written value is at or below the maximum position. A larger value leaves the count unchanged.
- R8: Counting up from the maximum position gives 0, and counting down from 0 gives the maximum position.
- R9: An accepted position write in the same cycle as a hardware count stroke wins, and that stroke is lost.
- R10: Decoder bit 8 inverts A and bit 7 inverts B. Decoder bit 10 then swaps the two inputs before decoding.
- R11: Register addresses are 0x00 for the position, 0x08 for the maximum, 0x28 for the decoder word and 0x2A for the run control word. Each register reads back its stored value.
- R12: A change on a pin shows in the count at the third rising clock edge after the pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinA | input | 1 | Asynchronous encoder input A |
| pinB | input | 1 | Asynchronous encoder input B |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte address |
| regWdata | input | 32 | Register write data (16-bit words use the low half) |
| regRdata | output | 32 | Read data for regAddr |
| posCount | output | 32 | Current position count |
| phaseErr | output | 1 | Sticky quadrature phase-error flag |

## Verification
The bench walks both quadrature directions through the wrap points at zero and at a small maximum. A design that compared against the wrong bound, or wrapped to zero on the way down, would drift away from the expected counts. It forces a diagonal jump of both inputs, which would count falsely if legality were not checked, and it tests writes just above and at the maximum. It lines up a position write with a count stroke on the same edge; a design that gave the stroke priority would end one count off. It also toggles the unused input in the pulse, up and down modes, and changes the swap and polarity settings, so a mapping error counts on the wrong input or the wrong edge.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] ADDR_POS = 8'h00;
  localparam logic [ADDR_W-1:0] ADDR_MAX = 8'h08;
  localparam logic [ADDR_W-1:0] ADDR_DEC = 8'h28;
  localparam logic [ADDR_W-1:0] ADDR_RUN = 8'h2A;

  typedef enum logic [1:0] {
    SRC_QUAD  = 2'd0,
    SRC_PDIR  = 2'd1,
    SRC_UP    = 2'd2,
    SRC_DOWN  = 2'd3
  } cntSrc_e;

  // Decoded configuration handed from the datapath registers to the control.
  typedef struct packed {
    cntSrc_e mode;
    logic    dblEdge;
    logic    swapAB;
    logic    invA;
    logic    invB;
    logic    en;
  } decCfg_t;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic cntUp;
    logic cntDn;
    logic phaseBad;
  } cntStrobe_t;

  // Classify a quadrature step: {up, down, illegal}.
  function automatic logic [2:0] quadStep(input logic [1:0] prevAB, input logic [1:0] curAB);
    logic [2:0] res;
    res = 3'b000;
    if ((prevAB ^ curAB) == 2'b11) res = 3'b001;
    else if (prevAB != curAB) begin
      unique case ({prevAB, curAB})
        4'b0001, 4'b0111, 4'b1110, 4'b1000: res = 3'b100;
        default: res = 3'b010;
      endcase
    end
    return res;
  endfunction

endpackage

// File: rtl/qpc_ctrl.sv
module qpc_ctrl
  import qpc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pinA,
  input  logic       pinB,
  input  decCfg_t    cfg,
  output cntStrobe_t strobes
);

  logic [SYNC_STAGES-1:0] syncA, syncB;
  logic polA, polB, curA, curB, prevA, prevB;
  logic riseA, fallA;
  logic [2:0] qStep;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevA <= 1'b0;
      prevB <= 1'b0;
    end else begin
      syncA <= {syncA[SYNC_STAGES-2:0], pinA};
      syncB <= {syncB[SYNC_STAGES-2:0], pinB};
      prevA <= curA;
      prevB <= curB;
    end
  end

  always_comb begin
    polA  = syncA[SYNC_STAGES-1] ^ cfg.invA;
    polB  = syncB[SYNC_STAGES-1] ^ cfg.invB;
    curA  = cfg.swapAB ? polB : polA;
    curB  = cfg.swapAB ? polA : polB;
    riseA = curA & ~prevA;
    fallA = ~curA & prevA;
    qStep = quadStep({prevA, prevB}, {curA, curB});
  end

  always_comb begin
    strobes = '0;
    if (cfg.en) begin
      unique case (cfg.mode)
        SRC_QUAD: begin
          strobes.cntUp    = qStep[2];
          strobes.cntDn    = qStep[1];
          strobes.phaseBad = qStep[0];
        end
        SRC_PDIR: begin
          strobes.cntUp = riseA & curB;
          strobes.cntDn = riseA & ~curB;
        end
        SRC_UP:   strobes.cntUp = riseA | (cfg.dblEdge & fallA);
        SRC_DOWN: strobes.cntDn = riseA | (cfg.dblEdge & fallA);
        default: ;
      endcase
    end
  end

  // R2: never both directions at once
  a_r2_one_direction: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.cntUp, strobes.cntDn}));

  // R4: B alone never counts in pulse/direction mode
  a_r4_b_no_count: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.mode == SRC_PDIR && curA == prevA) |-> !(strobes.cntUp || strobes.cntDn));

  // R5: B is ignored in up/down modes
  a_r5_b_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.mode[1] && curA == prevA) |-> !(strobes.cntUp || strobes.cntDn));

endmodule

// File: rtl/qpc_dpath.sv
module qpc_dpath
  import qpc_pkg::*;
#(
  parameter int              CNT_W     = 32,
  parameter logic [CNT_W-1:0] MAX_RESET = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CNT_W-1:0]  regWdata,
  input  cntStrobe_t        strobes,
  output logic [CNT_W-1:0]  regRdata,
  output logic [CNT_W-1:0]  posCount,
  output logic              phaseErr,
  output decCfg_t           cfg
);

  localparam int CTL_W = 16;

  logic [CNT_W-1:0] posCnt, maxPos, posNext;
  logic [CTL_W-1:0] decWord, runWord;
  logic             posWrOk;

  assign posWrOk = regWrEn && (regAddr == ADDR_POS) && (regWdata <= maxPos);

  always_comb begin
    posNext = posCnt;
    if (posWrOk)              posNext = regWdata;
    else if (strobes.cntUp)   posNext = (posCnt >= maxPos) ? '0 : posCnt + 1'b1;
    else if (strobes.cntDn)   posNext = (posCnt == '0) ? maxPos : posCnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      posCnt   <= '0;
      maxPos   <= MAX_RESET;
      decWord  <= '0;
      runWord  <= '0;
      phaseErr <= 1'b0;
    end else begin
      posCnt <= posNext;
      if (strobes.phaseBad) phaseErr <= 1'b1;
      if (regWrEn && regAddr == ADDR_MAX) maxPos  <= regWdata;
      if (regWrEn && regAddr == ADDR_DEC) decWord <= regWdata[CTL_W-1:0];
      if (regWrEn && regAddr == ADDR_RUN) runWord <= regWdata[CTL_W-1:0];
    end
  end

  always_comb begin
    cfg.mode    = cntSrc_e'(decWord[15:14]);
    cfg.dblEdge = decWord[11];
    cfg.swapAB  = decWord[10];
    cfg.invA    = decWord[8];
    cfg.invB    = decWord[7];
    cfg.en      = runWord[3];
  end

  always_comb begin
    unique case (regAddr)
      ADDR_POS: regRdata = posCnt;
      ADDR_MAX: regRdata = maxPos;
      ADDR_DEC: regRdata = {{(CNT_W-CTL_W){1'b0}}, decWord};
      ADDR_RUN: regRdata = {{(CNT_W-CTL_W){1'b0}}, runWord};
      default:  regRdata = '0;
    endcase
  end

  assign posCount = posCnt;

  // R3: phase error is sticky
  a_r3_sticky_error: assert property (@(posedge clk) disable iff (!rstN)
    phaseErr |=> phaseErr);

  // R6: disabled and no write keeps the count
  a_r6_hold_when_off: assert property (@(posedge clk) disable iff (!rstN)
    (!cfg.en && !posWrOk) |=> $stable(posCount));

  // R7: out-of-range write with no stroke leaves the count
  a_r7_reject_write: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_POS && regWdata > maxPos && !strobes.cntUp && !strobes.cntDn)
      |=> $stable(posCount));

  // R8: wrap at the top and at zero
  a_r8_wrap_up: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.cntUp && !posWrOk && posCount == maxPos) |=> posCount == '0);
  a_r8_wrap_down: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.cntDn && !posWrOk && posCount == '0) |=> posCount == $past(maxPos));

  // R9: an accepted write wins over a count stroke
  a_r9_write_wins: assert property (@(posedge clk) disable iff (!rstN)
    posWrOk |=> posCount == $past(regWdata));

endmodule

// File: rtl/quad_pos_counter.sv
module quad_pos_counter
  import qpc_pkg::*;
#(
  parameter int               CNT_W       = 32,
  parameter int               SYNC_STAGES = 2,
  parameter logic [CNT_W-1:0] MAX_RESET   = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pinA,
  input  logic              pinB,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CNT_W-1:0]  regWdata,
  output logic [CNT_W-1:0]  regRdata,
  output logic [CNT_W-1:0]  posCount,
  output logic              phaseErr
);

  decCfg_t    cfg;
  cntStrobe_t strobes;

  qpc_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .pinA(pinA), .pinB(pinB),
    .cfg(cfg), .strobes(strobes)
  );

  qpc_dpath #(.CNT_W(CNT_W), .MAX_RESET(MAX_RESET)) uDpath (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .strobes(strobes), .regRdata(regRdata),
    .posCount(posCount), .phaseErr(phaseErr), .cfg(cfg)
  );

endmodule

// File: tb/quad_pos_counter_test.sv
module quad_pos_counter_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pinA = 1'b0, pinB = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = 8'h00;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata, posCount;
  logic        phaseErr;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  logic expErr = 1'b0;

  typedef struct {
    string       tag;
    logic [31:0] cnt;
    logic        err;
  } expItem_t;

  expItem_t sbq[$];
  expItem_t monItem;

  quad_pos_counter uut (
    .clk(clk), .rstN(rstN), .pinA(pinA), .pinB(pinB),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .posCount(posCount), .phaseErr(phaseErr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Monitor: compare outputs against queued expectations.
  initial forever begin
    @(negedge clk);
    if (sbq.size() > 0) begin
      monItem = sbq.pop_front();
      checks++;
      if (posCount !== monItem.cnt || phaseErr !== monItem.err) begin
        fails++;
        $display("FAIL %s: count=%0d err=%0b expected count=%0d err=%0b",
                 monItem.tag, posCount, phaseErr, monItem.cnt, monItem.err);
      end
    end
  end

  // Driver: set pins, wait through sync and edge register (R12), queue expectation.
  task automatic step(input logic a, input logic b, input logic [31:0] exp, input string tag);
    @(negedge clk);
    pinA = a;
    pinB = b;
    repeat (4) @(posedge clk);
    sbq.push_back('{tag, exp, expErr});
  endtask

  task automatic expectCnt(input logic [31:0] exp, input string tag);
    @(posedge clk);
    sbq.push_back('{tag, exp, expErr});
  endtask

  task automatic regWrite(input logic [7:0] addr, input logic [31:0] data);
    @(negedge clk);
    regWrEn = 1'b1;
    regAddr = addr;
    regWdata = data;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readCheck(input logic [7:0] addr, input logic [31:0] exp, input string tag);
    @(negedge clk);
    regAddr = addr;
    #1;
    checks++;
    if (regRdata !== exp) begin
      fails++;
      $display("FAIL %s: read 0x%08h expected 0x%08h", tag, regRdata, exp);
    end
  endtask

  task automatic setMode(input logic [31:0] dec);
    regWrite(8'h2A, 32'h0);
    regWrite(8'h28, dec);
    regWrite(8'h2A, 32'h8);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    expectCnt(32'd0, "R1 reset count");
    readCheck(8'h08, 32'hFFFF_FFFF, "R1 reset max");
    readCheck(8'h28, 32'h0, "R1 reset decoder word");
    readCheck(8'h2A, 32'h0, "R1 reset run word");

    regWrite(8'h08, 32'd100);
    readCheck(8'h08, 32'd100, "R11 max readback");
    regWrite(8'h2A, 32'h8);

    // R2 quadrature up and down
    step(0, 1, 1, "R2 quad up 1");
    step(1, 1, 2, "R2 quad up 2");
    step(1, 0, 3, "R2 quad up 3");
    step(0, 0, 4, "R2 quad up 4");
    step(1, 0, 3, "R2 quad down 1");
    step(1, 1, 2, "R2 quad down 2");
    step(0, 1, 1, "R2 quad down 3");
    step(0, 0, 0, "R2 quad down 4");
    // R8 wraps
    step(1, 0, 100, "R8 wrap down to max");
    step(0, 0, 0, "R8 wrap up to zero");
    // R3 illegal jump
    expErr = 1'b1;
    step(1, 1, 0, "R3 illegal jump");
    step(1, 0, 1, "R3 count resumes, error sticky");

    // R7 range check on writes
    regWrite(8'h00, 32'd101);
    expectCnt(32'd1, "R7 write above max rejected");
    regWrite(8'h00, 32'd100);
    expectCnt(32'd100, "R7 write at max accepted");
    regWrite(8'h00, 32'd50);
    expectCnt(32'd50, "R7 write below max");

    // R6 disable
    regWrite(8'h2A, 32'h0);
    step(0, 0, 50, "R6 disabled holds");

    // R4 pulse/direction
    setMode(32'h4000);
    step(0, 1, 50, "R4 B edge no count");
    step(1, 1, 51, "R4 A rise with B high up");
    step(0, 1, 51, "R4 A fall no count");
    step(0, 0, 51, "R4 B fall no count");
    step(1, 0, 50, "R4 A rise with B low down");

    // R5 up mode, single then double edge
    setMode(32'h8000);
    step(0, 0, 50, "R5 up fall ignored");
    step(1, 0, 51, "R5 up rise counts");
    step(1, 1, 51, "R5 up B ignored");
    setMode(32'h8800);
    step(0, 1, 52, "R5 up both edges fall");
    step(1, 1, 53, "R5 up both edges rise");
    setMode(32'hC000);
    step(0, 1, 53, "R5 down fall ignored");
    step(1, 1, 52, "R5 down rise counts");

    // R10 swap and invert
    setMode(32'h8400);
    step(0, 1, 52, "R10 swap A pin ignored");
    step(0, 0, 52, "R10 swap B fall ignored");
    step(0, 1, 53, "R10 swap B rise counts");
    setMode(32'h8100);
    step(1, 1, 53, "R10 invert A rise is fall");
    step(0, 1, 54, "R10 invert A fall is rise");
    step(1, 1, 54, "R10 invert A rise again");

    // R9 write collides with a count stroke
    @(negedge clk);
    pinA = 1'b0;
    @(posedge clk);
    @(posedge clk);
    regWrite(8'h00, 32'd7);
    repeat (3) @(posedge clk);
    sbq.push_back('{"R9 write wins over stroke", 32'd7, expErr});

    // R11 readback
    readCheck(8'h28, 32'h8100, "R11 decoder readback");
    readCheck(8'h2A, 32'h0008, "R11 run word readback");
    readCheck(8'h00, 32'd7, "R11 position readback");

    wait (sbq.size() == 0);
    @(posedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule